// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps a small associative record of loads that were moved ahead of stores. When such an early load issues, it writes an entry keyed by its destination register number. The entry holds the byte address and the access size. Each store presents its own byte range, and every recorded entry whose range touches it is dropped. Later, a check operation names a register. The block answers whether the early load is still valid: a hit means the speculation held. On a miss, the check either asks for the load to be redone (load-check kind) or asks for a branch to recovery code (advanced-check kind). A check can also clear the entry it consulted.

The table has a fixed number of entries. A load that finds its register already recorded overwrites that slot. If the register is not recorded, the load takes the lowest free slot. If no slot is free, it takes the slot named by a round-robin victim pointer. A speculative early load that deferred a fault does not record anything, and it removes any older entry for its register, so the later check fails. A synchronous flush empties the table.

An occupancy state machine tracks how full the table is and steers the choice of slot. It has three states: `OCC_EMPTY`, `OCC_PARTIAL` and `OCC_FULL`. The transitions are FILL (`OCC_EMPTY` to `OCC_PARTIAL`, or straight to `OCC_FULL` when one entry is the whole table), TOP_OFF (`OCC_PARTIAL` to `OCC_FULL`), DRAIN (`OCC_FULL` to `OCC_PARTIAL`, or any non-empty state back to `OCC_EMPTY` when the last entry goes) and WIPE (any state to `OCC_EMPTY` on flush). In `OCC_FULL`, a load for an unrecorded register evicts a victim.

Top module: `spec_track_table`

## Requirements
- R1: After reset and after any flush, the table holds no entries, so every check misses. A load in the same cycle as a flush records nothing.
- R2: A check request in cycle t gives `chk_done_o` high in cycle t+1 with exactly one of `chk_hit_o`, `chk_recover_o`, `chk_reload_o` high. With no request, all four outputs are low.
- R3: A non-deferred early load records its register, so a later check of that register hits until the entry is removed.
- R4: On a miss, `chk_kind_i`=0 (advanced-check) raises `chk_recover_o` and `chk_kind_i`=1 (load-check) raises `chk_reload_o`.
- R5: A store invalidates every entry whose byte range overlaps its own. An access of size code s covers 2^s bytes starting at its address. A store whose range only touches an entry's range without overlapping it leaves the entry in place.
- R6: A check with `chk_clear_i`=1 reports the entry's state and then removes the entry. A check without the clear leaves the entry in place.
- R7: An early load with `ld_defer_i`=1 records nothing and removes any existing entry for its register.
- R8: A new early load to a register that is already recorded replaces the old address and size.
- R9: In a full table, a load for an unrecorded register evicts the slot at the victim pointer. The pointer is 0 after reset, advances by one (wrapping) per eviction, and is not moved by flush. Free slots are filled lowest index first.
- R10: A check sees the table as it was before the same cycle's updates. A load beats a same-cycle overlapping store or clear of the same slot. A flush beats everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| ld_valid_i | input | 1 | Early load present |
| ld_defer_i | input | 1 | Early load deferred a fault |
| ld_reg_i | input | REG_W | Load destination register |
| ld_addr_i | input | ADDR_W | Load byte address |
| ld_size_i | input | SIZE_W | Load size code (2^s bytes) |
| st_valid_i | input | 1 | Store present |
| st_addr_i | input | ADDR_W | Store byte address |
| st_size_i | input | SIZE_W | Store size code |
| chk_valid_i | input | 1 | Check request |
| chk_reg_i | input | REG_W | Register to check |
| chk_kind_i | input | 1 | 0 advanced-check, 1 load-check |
| chk_clear_i | input | 1 | Remove entry after the check |
| chk_done_o | output | 1 | Check result valid |
| chk_hit_o | output | 1 | Entry was present |
| chk_recover_o | output | 1 | Branch to recovery code |
| chk_reload_o | output | 1 | Redo the load |

## Verification
The risky overlap is a check and a table update falling in the same cycle: a check and an overlapping store, a check and an insert to the same register, and a check-clear and a load to the same register. Directed sequences issue each pair in one cycle and then check again in the next cycle. The first answer must reflect the old table and the second answer the new one. A scoreboard model then drives a long mix in which loads, stores, checks and the occasional flush collide freely.

// File: rtl/stt_pkg.sv
package stt_pkg;
    typedef enum logic {
        CHK_ADV = 1'b0,
        CHK_LD  = 1'b1
    } chk_kind_e;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;
endpackage

// File: rtl/stt_entry.sv
module stt_entry #(
    parameter int REG_W  = 7,
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  ld_reg_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [SIZE_W-1:0] ld_size_i,
    input  logic              kill_i,
    input  logic              clr_i,
    input  logic [REG_W-1:0]  chk_reg_i,
    input  logic              st_valid_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [SIZE_W-1:0] st_size_i,
    output logic              valid_o,
    output logic              valid_nxt_o,
    output logic              chk_match_o,
    output logic              ld_match_o
);
    localparam int EXT_W = ADDR_W + 1;

    logic              valid_q;
    logic [REG_W-1:0]  reg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size_q;
    logic [EXT_W-1:0]  my_end, st_end;
    logic              overlap, drop;

    // exclusive end of a byte range
    function automatic logic [EXT_W-1:0] span_end(input logic [ADDR_W-1:0] a,
                                                 input logic [SIZE_W-1:0] s);
        return {1'b0, a} + (EXT_W'(1) << s);
    endfunction

    always_comb begin
        my_end      = span_end(addr_q, size_q);
        st_end      = span_end(st_addr_i, st_size_i);
        overlap     = ({1'b0, addr_q} < st_end) && ({1'b0, st_addr_i} < my_end);
        chk_match_o = valid_q && (reg_q == chk_reg_i);
        ld_match_o  = valid_q && (reg_q == ld_reg_i);
        drop        = (st_valid_i && valid_q && overlap)
                    || (clr_i && chk_match_o)
                    || (kill_i && ld_match_o);
        if (flush_i)   valid_nxt_o = 1'b0;
        else if (wr_i) valid_nxt_o = 1'b1;
        else if (drop) valid_nxt_o = 1'b0;
        else           valid_nxt_o = valid_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            reg_q   <= '0;
            addr_q  <= '0;
            size_q  <= '0;
        end else begin
            valid_q <= valid_nxt_o;
            if (wr_i && !flush_i) begin
                reg_q  <= ld_reg_i;
                addr_q <= ld_addr_i;
                size_q <= ld_size_i;
            end
        end
    end

    assign valid_o = valid_q;
endmodule

// File: rtl/stt_alloc.sv
module stt_alloc #(
    parameter int N_ENTRIES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_go_i,
    input  logic                 full_i,
    input  logic [N_ENTRIES-1:0] valid_i,
    input  logic [N_ENTRIES-1:0] ld_match_i,
    output logic [N_ENTRIES-1:0] wr_vec_o
);
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q, hit_idx, free_idx, tgt;
    logic             hit_any, evict;

    always_comb begin
        hit_any  = 1'b0;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (ld_match_i[i]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) free_idx = IDX_W'(i);
        end
        if (hit_any)     tgt = hit_idx;
        else if (full_i) tgt = ptr_q;
        else             tgt = free_idx;
        evict = ld_go_i && !hit_any && full_i;
        for (int i = 0; i < N_ENTRIES; i++) begin
            wr_vec_o[i] = ld_go_i && (tgt == IDX_W'(i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ptr_q <= '0;
        else if (evict) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
endmodule

// File: rtl/stt_ctrl.sv
module stt_ctrl
    import stt_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_ENTRIES-1:0] valid_nxt_i,
    input  logic                 chk_valid_i,
    input  chk_kind_e            chk_kind_i,
    input  logic                 chk_hit_i,
    output logic                 full_o,
    output logic                 chk_done_o,
    output logic                 chk_hit_o,
    output logic                 chk_recover_o,
    output logic                 chk_reload_o
);
    localparam int CNT_W = $clog2(N_ENTRIES + 1);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(N_ENTRIES);

    occ_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt;
    logic             none_left, all_used;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N_ENTRIES; i++) cnt = cnt + CNT_W'(valid_nxt_i[i]);
        none_left = (cnt == '0);
        all_used  = (cnt == TOP);
    end

    // next occupancy: FILL, TOP_OFF, DRAIN, WIPE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (all_used)        state_d = OCC_FULL;
                else if (!none_left) state_d = OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (none_left)     state_d = OCC_EMPTY;
                else if (all_used) state_d = OCC_FULL;
            end
            OCC_FULL: begin
                if (none_left)      state_d = OCC_EMPTY;
                else if (!all_used) state_d = OCC_PARTIAL;
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_done_o    <= 1'b0;
            chk_hit_o     <= 1'b0;
            chk_recover_o <= 1'b0;
            chk_reload_o  <= 1'b0;
        end else begin
            chk_done_o    <= chk_valid_i;
            chk_hit_o     <= chk_valid_i && chk_hit_i;
            chk_recover_o <= chk_valid_i && !chk_hit_i && (chk_kind_i == CHK_ADV);
            chk_reload_o  <= chk_valid_i && !chk_hit_i && (chk_kind_i == CHK_LD);
        end
    end

    assign full_o = (state_q == OCC_FULL);
endmodule

// File: rtl/spec_track_table.sv
module spec_track_table
    import stt_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int REG_W     = 7,
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              ld_valid_i,
    input  logic              ld_defer_i,
    input  logic [REG_W-1:0]  ld_reg_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [SIZE_W-1:0] ld_size_i,
    input  logic              st_valid_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [SIZE_W-1:0] st_size_i,
    input  logic              chk_valid_i,
    input  logic [REG_W-1:0]  chk_reg_i,
    input  logic              chk_kind_i,
    input  logic              chk_clear_i,
    output logic              chk_done_o,
    output logic              chk_hit_o,
    output logic              chk_recover_o,
    output logic              chk_reload_o
);
    logic [N_ENTRIES-1:0] valid, valid_nxt, chk_match, ld_match, wr_vec;
    logic ld_go, ld_kill, chk_clr, full;

    assign ld_go   = ld_valid_i && !ld_defer_i && !flush_i;
    assign ld_kill = ld_valid_i && ld_defer_i && !flush_i;
    assign chk_clr = chk_valid_i && chk_clear_i;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        stt_entry #(.REG_W(REG_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_entry (
            .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .wr_i(wr_vec[g]),
            .ld_reg_i(ld_reg_i), .ld_addr_i(ld_addr_i), .ld_size_i(ld_size_i),
            .kill_i(ld_kill), .clr_i(chk_clr), .chk_reg_i(chk_reg_i),
            .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_size_i(st_size_i),
            .valid_o(valid[g]), .valid_nxt_o(valid_nxt[g]),
            .chk_match_o(chk_match[g]), .ld_match_o(ld_match[g])
        );
    end

    stt_alloc #(.N_ENTRIES(N_ENTRIES)) u_alloc (
        .clk(clk), .rst_n(rst_n), .ld_go_i(ld_go), .full_i(full),
        .valid_i(valid), .ld_match_i(ld_match), .wr_vec_o(wr_vec)
    );

    stt_ctrl #(.N_ENTRIES(N_ENTRIES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .valid_nxt_i(valid_nxt),
        .chk_valid_i(chk_valid_i), .chk_kind_i(chk_kind_e'(chk_kind_i)),
        .chk_hit_i(|chk_match), .full_o(full),
        .chk_done_o(chk_done_o), .chk_hit_o(chk_hit_o),
        .chk_recover_o(chk_recover_o), .chk_reload_o(chk_reload_o)
    );
endmodule

// File: rtl/stt_checker.sv
module stt_checker #(
    parameter int REG_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_i,
    input logic             ld_valid_i,
    input logic             ld_defer_i,
    input logic [REG_W-1:0] ld_reg_i,
    input logic             chk_valid_i,
    input logic [REG_W-1:0] chk_reg_i,
    input logic             chk_kind_i,
    input logic             chk_clear_i,
    input logic             chk_done_o,
    input logic             chk_hit_o,
    input logic             chk_recover_o,
    input logic             chk_reload_o
);
    p_done_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid_i |=> chk_done_o);
    p_no_stray_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid_i |=> !chk_done_o);
    p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done_o |-> $countones({chk_hit_o, chk_recover_o, chk_reload_o}) == 1);
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_done_o |-> !(chk_hit_o || chk_recover_o || chk_reload_o));
    p_recover_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_recover_o |-> !$past(chk_kind_i));
    p_reload_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_reload_o |-> $past(chk_kind_i));
    p_insert_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid_i && !ld_defer_i && !flush_i ##1
         chk_valid_i && chk_reg_i == $past(ld_reg_i)) |=> chk_hit_o);
    p_flush_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i ##1 chk_valid_i) |=> !chk_hit_o);
    p_defer_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid_i && ld_defer_i && !flush_i ##1
         chk_valid_i && chk_reg_i == $past(ld_reg_i)) |=> !chk_hit_o);
    p_clear_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid_i && chk_clear_i && !(ld_valid_i && !ld_defer_i && ld_reg_i == chk_reg_i) ##1
         chk_valid_i && chk_reg_i == $past(chk_reg_i)) |=> !chk_hit_o);
endmodule

bind spec_track_table stt_checker #(.REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .ld_valid_i(ld_valid_i),
    .ld_defer_i(ld_defer_i), .ld_reg_i(ld_reg_i), .chk_valid_i(chk_valid_i),
    .chk_reg_i(chk_reg_i), .chk_kind_i(chk_kind_i), .chk_clear_i(chk_clear_i),
    .chk_done_o(chk_done_o), .chk_hit_o(chk_hit_o),
    .chk_recover_o(chk_recover_o), .chk_reload_o(chk_reload_o)
);

// File: tb/spec_track_table_tb.sv
module spec_track_table_tb;
    localparam int N = 8;
    localparam int RW = 7;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_i = 0, ld_valid_i = 0, ld_defer_i = 0, st_valid_i = 0;
    logic chk_valid_i = 0, chk_kind_i = 0, chk_clear_i = 0;
    logic [RW-1:0] ld_reg_i = '0, chk_reg_i = '0;
    logic [AW-1:0] ld_addr_i = '0, st_addr_i = '0;
    logic [1:0] ld_size_i = '0, st_size_i = '0;
    logic chk_done_o, chk_hit_o, chk_recover_o, chk_reload_o;

    int checks = 0, fails = 0, cyc = 0;

    typedef struct {
        int    due;
        bit    hit;
        bit    kind;
        string tag;
    } exp_t;
    exp_t q[$];

    bit m_v[N];
    int m_reg[N];
    longint m_addr[N];
    int m_sz[N];
    int m_ptr = 0;

    spec_track_table u_dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .ld_valid_i(ld_valid_i),
        .ld_defer_i(ld_defer_i), .ld_reg_i(ld_reg_i), .ld_addr_i(ld_addr_i),
        .ld_size_i(ld_size_i), .st_valid_i(st_valid_i), .st_addr_i(st_addr_i),
        .st_size_i(st_size_i), .chk_valid_i(chk_valid_i), .chk_reg_i(chk_reg_i),
        .chk_kind_i(chk_kind_i), .chk_clear_i(chk_clear_i), .chk_done_o(chk_done_o),
        .chk_hit_o(chk_hit_o), .chk_recover_o(chk_recover_o), .chk_reload_o(chk_reload_o)
    );

    always #4ns clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit ovl(longint a, int as, longint b, int bs);
        return (a < b + (longint'(1) << bs)) && (b < a + (longint'(1) << as));
    endfunction

    task automatic drive(bit ld, int lr, longint la, int ls, bit ldf,
                         bit st, longint sa, int ss,
                         bit ck, int cr, bit kd, bit cl, bit fl, string tag);
        bit pv[N];
        bit hit, full, mhit, go, kill, drop;
        int tgt, free_i;
        @(negedge clk);
        flush_i = fl; ld_valid_i = ld; ld_defer_i = ldf; ld_reg_i = RW'(lr);
        ld_addr_i = AW'(la); ld_size_i = 2'(ls); st_valid_i = st;
        st_addr_i = AW'(sa); st_size_i = 2'(ss); chk_valid_i = ck;
        chk_reg_i = RW'(cr); chk_kind_i = kd; chk_clear_i = cl;
        hit = 0; mhit = 0; full = 1; tgt = 0; free_i = -1;
        for (int i = 0; i < N; i++) begin
            pv[i] = m_v[i];
            if (m_v[i] && m_reg[i] == cr) hit = 1;
            if (m_v[i] && m_reg[i] == lr) begin mhit = 1; tgt = i; end
            if (!m_v[i]) begin full = 0; if (free_i < 0) free_i = i; end
        end
        if (ck) q.push_back('{cyc + 1, hit, kd, tag});
        if (!mhit) tgt = full ? m_ptr : free_i;
        go = ld && !ldf && !fl;
        kill = ld && ldf && !fl;
        for (int i = 0; i < N; i++) begin
            drop = pv[i] && ((st && ovl(m_addr[i], m_sz[i], sa, ss))
                          || (ck && cl && m_reg[i] == cr)
                          || (kill && m_reg[i] == lr));
            if (fl) m_v[i] = 0;
            else if (go && i == tgt) begin
                m_v[i] = 1; m_reg[i] = lr; m_addr[i] = la; m_sz[i] = ls;
            end else if (drop) m_v[i] = 0;
        end
        if (go && !mhit && full) m_ptr = (m_ptr + 1) % N;
    endtask

    task automatic t_ld(int r, longint a, int s);
        drive(1, r, a, s, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask
    task automatic t_st(longint a, int s);
        drive(0, 0, 0, 0, 0, 1, a, s, 0, 0, 0, 0, 0, "");
    endtask
    task automatic t_chk(int r, bit kd, bit cl, string tag);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, r, kd, cl, 0, tag);
    endtask
    task automatic t_idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // monitor: pop and compare one cycle after each check request
    initial begin
        forever begin
            @(posedge clk);
            #1ns;
            if (rst_n) begin
                if (q.size() > 0 && q[0].due == cyc) begin
                    exp_t e;
                    bit er, ed;
                    e = q.pop_front();
                    er = !e.hit && !e.kind;
                    ed = !e.hit && e.kind;
                    checks++;
                    if (chk_done_o !== 1'b1 || chk_hit_o !== e.hit ||
                        chk_recover_o !== er || chk_reload_o !== ed) begin
                        fails++;
                        $display("FAIL %s: actual done=%b hit=%b rec=%b rel=%b expected done=1 hit=%b rec=%b rel=%b",
                                 e.tag, chk_done_o, chk_hit_o, chk_recover_o, chk_reload_o, e.hit, er, ed);
                    end
                end else if (chk_done_o || chk_hit_o || chk_recover_o || chk_reload_o) begin
                    checks++;
                    fails++;
                    $display("FAIL R2 stray result: actual done=%b hit=%b rec=%b rel=%b expected all 0",
                             chk_done_o, chk_hit_o, chk_recover_o, chk_reload_o);
                end
            end
        end
    end

    initial begin
        #(8ns * 200000);
        fails++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        checks++;
        if (chk_done_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual done=%b expected 0", chk_done_o);
        end
        t_chk(5, 0, 0, "R1 R4 empty adv-check recovers");
        t_chk(5, 1, 0, "R4 empty load-check reloads");
        // R3 insert and hit
        t_ld(5, 'h100, 3);
        t_chk(5, 0, 0, "R3 hit after insert");
        t_chk(5, 1, 0, "R6 no-clear keeps entry");
        t_chk(5, 1, 0, "R6 still present");
        // R5 byte-range overlap
        t_st('h108, 2);
        t_chk(5, 0, 0, "R5 adjacent store keeps entry");
        t_st('h107, 0);
        t_chk(5, 0, 0, "R5 overlapping byte kills entry");
        t_ld(6, 'h200, 2);
        t_st('h1FE, 1);
        t_chk(6, 0, 0, "R5 store below range keeps entry");
        t_st('h1FC, 3);
        t_chk(6, 1, 0, "R5 wide store covering range kills");
        // R6 clear
        t_ld(7, 'h280, 1);
        t_chk(7, 1, 1, "R6 clear check still hits");
        t_chk(7, 1, 0, "R6 entry gone after clear");
        // R8 replace
        t_ld(8, 'h300, 0);
        t_ld(8, 'h400, 0);
        t_st('h300, 0);
        t_chk(8, 0, 0, "R8 old address no longer tracked");
        t_st('h400, 0);
        t_chk(8, 0, 0, "R8 new address tracked");
        // R7 deferred
        drive(1, 9, 'h500, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, "");
        t_chk(9, 0, 0, "R7 deferred load records nothing");
        t_ld(9, 'h500, 2);
        drive(1, 9, 'h540, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, "");
        t_chk(9, 1, 0, "R7 deferred load removes older entry");
        // R10 same-cycle ordering
        drive(1, 10, 'h600, 2, 0, 0, 0, 0, 1, 10, 0, 0, 0, "R10 check sees pre-insert table");
        t_chk(10, 0, 0, "R10 insert visible next cycle");
        drive(1, 11, 'h700, 2, 0, 1, 'h700, 2, 0, 0, 0, 0, 0, "");
        t_chk(11, 0, 0, "R10 load beats same-cycle store");
        drive(0, 0, 0, 0, 0, 1, 'h600, 0, 1, 10, 0, 0, 0, "R10 check before same-cycle store");
        t_chk(10, 0, 0, "R10 store applied after check");
        t_ld(12, 'h800, 2);
        drive(1, 12, 'h900, 2, 0, 0, 0, 0, 1, 12, 1, 1, 0, "R10 clear with reload same reg");
        t_chk(12, 0, 0, "R10 load beats same-cycle clear");
        // R1 flush
        drive(1, 13, 'hA00, 2, 0, 0, 0, 0, 0, 0, 0, 0, 1, "");
        t_chk(11, 0, 0, "R1 flush empties table");
        t_chk(13, 1, 0, "R1 load with flush records nothing");
        // R9 round-robin eviction
        for (int i = 0; i < N; i++) t_ld(20 + i, 'h1000 + 16 * i, 2);
        t_chk(27, 0, 0, "R9 table full, last insert present");
        t_ld(28, 'h2000, 2);
        t_chk(20, 0, 0, "R9 slot 0 evicted first");
        t_chk(28, 0, 0, "R9 new entry present");
        t_chk(21, 0, 0, "R9 slot 1 kept");
        t_ld(29, 'h2100, 2);
        t_chk(21, 1, 0, "R9 slot 1 evicted next");
        t_ld(22, 'h3000, 2);
        t_chk(22, 0, 0, "R9 R8 reload of recorded reg does not evict");
        t_chk(23, 0, 0, "R9 slot 3 kept");
        // mixed traffic against the model
        for (int k = 0; k < 600; k++) begin
            int r1 = 40 + $urandom_range(0, 11);
            int r2 = 40 + $urandom_range(0, 11);
            drive($urandom_range(0, 1), r1, 'h4000 + $urandom_range(0, 63), $urandom_range(0, 3),
                  ($urandom_range(0, 7) == 0), $urandom_range(0, 2) == 0,
                  'h4000 + $urandom_range(0, 63), $urandom_range(0, 3),
                  $urandom_range(0, 1), r2, $urandom_range(0, 1), $urandom_range(0, 3) == 0,
                  $urandom_range(0, 59) == 0, "R2 R3 R5 R9 mixed traffic");
        end
        repeat (3) t_idle();
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2 results missing: actual pending=%0d expected 0", q.size());
        end
        summary();
        $finish;
    end
endmodule